// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a byte-wide asynchronous static RAM. The requester presents an address, a write byte and a read/write flag with a valid strobe. The controller takes the request in a single cycle and runs the memory-side sequence. It then returns a one-cycle acknowledge, and after a read the captured byte is on the read-data output. All memory-side pins come straight from flops. The shared data bus is modelled as three signals: an output byte, an input byte and an output enable.

The memory is selected only while the active-low enable is low and the active-high enable is high. Between accesses the controller deselects the memory, which floats its data pins and lets it drop into standby. Every timing interval is a clock-cycle count set by a parameter. Each count is the nanosecond figure divided by the clock period and rounded up; the defaults assume a 10 ns clock. The intervals are the read cycle (`READ_CYCLES`, 6), the write-enable low pulse (`WE_PULSE_CYCLES`, 3), the write data setup (`DATA_SETUP_CYCLES`, 3) and the memory's bus release after output enable rises (`RELEASE_CYCLES`, 3). The write pulse actually used lasts LOW = max(`WE_PULSE_CYCLES`, `DATA_SETUP_CYCLES`, `READ_CYCLES`-1) cycles. With that length the address is held for a full write cycle before the pulse ends. `READ_CYCLES` must be at least 2 and `RELEASE_CYCLES` at least 1.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and in the first cycle after any acknowledge, the memory is idle: `memCe1N`=1, `memCe2`=0, `memOeN`=1, `memWeN`=1, `memDqOe`=0, `reqAck`=0. After reset `rdData` is 0.
- R2: A request is accepted at a rising edge where `reqValid`=1 and `reqAck`=0 while the controller is idle. For a read (`reqWrite`=0), the memory is selected with `memOeN`=0 and `memWeN`=1 for exactly `READ_CYCLES` cycles. The address is held constant during that time. `rdData` takes `memDqIn` at the edge that ends the last of those cycles. `reqAck` is high in the cycle after that edge, which is `READ_CYCLES` edges after the acceptance edge.
- R3: A write (`reqWrite`=1) runs in three steps. First comes one setup cycle: selected, `memWeN`=1, `memOeN`=1 and the byte driven. Then `memWeN`=0 for LOW cycles. Last comes one release cycle, still selected and driving, with `memWeN`=1. `reqAck` follows LOW+2 edges after the acceptance edge.
- R4: `reqAck` is high for exactly one cycle per access. A request held high through the acknowledge cycle is not taken a second time.
- R5: `memAddr` changes only while `memWeN` is high and was high in the cycle before. While `memWeN` is low, `memAddr` and `memDqOut` are stable and `memDqOe`=1.
- R6: `memDqOe` is high only while `memOeN` is high, and at least `RELEASE_CYCLES` cycles after `memOeN` last rose. The memory therefore never drives against the controller.
- R7: A read returns the byte most recently written to that address. `rdData` holds its value until the next read completes.
- R8: `memOeN` and `memWeN` are never low in the same cycle.
- R9: Address, write data and the read/write flag are sampled only at the acceptance edge. Changing them during an access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Byte to write |
| reqAck | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Last byte read |
| memCe1N | output | 1 | Memory enable, active low |
| memCe2 | output | 1 | Memory enable, active high |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDqOut | output | DATA_W | Data bus, controller to memory |
| memDqIn | input | DATA_W | Data bus, memory to controller |
| memDqOe | output | 1 | Controller drives the data bus |

## Verification
Several rules are checked on every cycle by properties in the RTL. These are the quiet pins while the memory is deselected and the single-cycle acknowledge. They also cover the address moving only with write enable high, and the address and data held still through the write pulse. The exact pulse and read-window lengths are checked too, along with the bus turnaround gap and output and write enable never being low together. Other behaviour can only be shown by the bench's scenarios, driven against a cycle-counting memory model. These are whether reads return the data most recently written across every address of a small configuration, and whether the model ever sees contention or a timing shortfall. They also include request fields that change during an access being ignored, and the absence of any second acceptance while the acknowledge is high.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_END,
    ST_TURN
  } ctrlState_t;

  // select/outEn/wrEn/busDrive describe the pins for the next cycle;
  // loadReq/capture/ackEvent act at the coming edge.
  typedef struct packed {
    logic select;
    logic outEn;
    logic wrEn;
    logic busDrive;
    logic loadReq;
    logic capture;
    logic ackEvent;
  } ctrlStrobes_t;

  function automatic int maxOf3(int a, int b, int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // write-enable low length: pulse width, data setup and address-to-end window
  function automatic int lowCycles(int wePulse, int dataSetup, int readCycles);
    return maxOf3(wePulse, dataSetup, readCycles - 1);
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int READ_CYCLES       = 6,
  parameter int WE_PULSE_CYCLES   = 3,
  parameter int DATA_SETUP_CYCLES = 3,
  parameter int RELEASE_CYCLES    = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         ackPending,
  output ctrlStrobes_t strobes
);

  localparam int LOW_CYCLES = lowCycles(WE_PULSE_CYCLES, DATA_SETUP_CYCLES, READ_CYCLES);
  localparam int CNT_MAX    = maxOf3(READ_CYCLES, LOW_CYCLES, RELEASE_CYCLES);
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = (cnt != '0) ? cnt - CNT_W'(1) : '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && !ackPending) begin
          if (reqWrite) begin
            stateNext = ST_WR_SETUP;
          end else begin
            stateNext = ST_RD_ACCESS;
            cntNext   = CNT_W'(READ_CYCLES - 2);
          end
        end
      end
      ST_RD_ACCESS:  if (cnt == '0) stateNext = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin
        stateNext = ST_TURN;
        cntNext   = CNT_W'(RELEASE_CYCLES - 1);
      end
      ST_WR_SETUP: begin
        stateNext = ST_WR_PULSE;
        cntNext   = CNT_W'(LOW_CYCLES - 1);
      end
      ST_WR_PULSE:   if (cnt == '0) stateNext = ST_WR_END;
      ST_WR_END:     stateNext = ST_IDLE;
      ST_TURN:       if (cnt == '0) stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    strobes.select   = stateNext inside {ST_RD_ACCESS, ST_RD_CAPTURE,
                                         ST_WR_SETUP, ST_WR_PULSE, ST_WR_END};
    strobes.outEn    = stateNext inside {ST_RD_ACCESS, ST_RD_CAPTURE};
    strobes.wrEn     = (stateNext == ST_WR_PULSE);
    strobes.busDrive = stateNext inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_END};
    strobes.loadReq  = (state == ST_IDLE) && (stateNext != ST_IDLE);
    strobes.capture  = (state == ST_RD_CAPTURE);
    strobes.ackEvent = (state == ST_RD_CAPTURE) || (state == ST_WR_END);
  end

  // R4: no request is taken while the previous acknowledge is still showing
  a_r4_no_accept_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ackPending) |=> (state == ST_IDLE));

  // R2: capture is always reached through the access phase
  a_r2_capture_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_CAPTURE) |-> ($past(state) == ST_RD_ACCESS || READ_CYCLES < 2));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 8,
  parameter int READ_CYCLES    = 6,
  parameter int LOW_CYCLES     = 5,
  parameter int RELEASE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  localparam int RUN_MAX = maxOf3(READ_CYCLES, LOW_CYCLES, RELEASE_CYCLES) + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [DATA_W-1:0] wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCe1N <= 1'b1;
      memCe2  <= 1'b0;
      memOeN  <= 1'b1;
      memWeN  <= 1'b1;
      memDqOe <= 1'b0;
      memAddr <= '0;
      wrData  <= '0;
      rdData  <= '0;
      reqAck  <= 1'b0;
    end else begin
      memCe1N <= !strobes.select;
      memCe2  <= strobes.select;
      memOeN  <= !strobes.outEn;
      memWeN  <= !strobes.wrEn;
      memDqOe <= strobes.busDrive;
      reqAck  <= strobes.ackEvent;
      if (strobes.loadReq) begin
        memAddr <= reqAddr;
        wrData  <= reqWdata;
      end
      if (strobes.capture) rdData <= memDqIn;
    end
  end

  assign memDqOut = wrData;

  // run-length counters on the pins, used by the checks below
  logic [RUN_W-1:0] weLowRun, oeLowRun, oeHighRun;

  function automatic logic [RUN_W-1:0] bump(logic [RUN_W-1:0] v);
    return (v == RUN_W'(RUN_MAX)) ? v : v + RUN_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun  <= '0;
      oeLowRun  <= '0;
      oeHighRun <= RUN_W'(RUN_MAX);
    end else begin
      weLowRun  <= memWeN  ? '0 : bump(weLowRun);
      oeLowRun  <= memOeN  ? '0 : bump(oeLowRun);
      oeHighRun <= !memOeN ? '0 : bump(oeHighRun);
    end
  end

  // R1: a deselected memory sees no strobe and no driven bus
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    memCe1N |-> (!memCe2 && memOeN && memWeN && !memDqOe));

  // R4: acknowledge lasts one cycle
  a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R2: capture happens in the last cycle of a full read window
  a_r2_read_window: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> (!memOeN && oeLowRun == RUN_W'(READ_CYCLES - 1)));

  // R3: write enable stays low for exactly the derived pulse length
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowRun == RUN_W'(LOW_CYCLES)));

  // R5: address moves only with write enable high on both sides
  a_r5_addr_we: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> (memWeN && $past(memWeN)));

  // R5: data and address still while writing
  a_r5_write_data: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memDqOut) && $stable(memAddr) && memDqOe));

  // R6: controller drives only after the memory has released the bus
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && oeHighRun >= RUN_W'(RELEASE_CYCLES)));

  // R8: output enable and write enable never both active
  a_r8_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W            = 18,
  parameter int DATA_W            = 8,
  parameter int READ_CYCLES       = 6,
  parameter int WE_PULSE_CYCLES   = 3,
  parameter int DATA_SETUP_CYCLES = 3,
  parameter int RELEASE_CYCLES    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  localparam int LOW_CYCLES = lowCycles(WE_PULSE_CYCLES, DATA_SETUP_CYCLES, READ_CYCLES);

  ctrlStrobes_t strobes;

  sram_ctrl_fsm #(
    .READ_CYCLES      (READ_CYCLES),
    .WE_PULSE_CYCLES  (WE_PULSE_CYCLES),
    .DATA_SETUP_CYCLES(DATA_SETUP_CYCLES),
    .RELEASE_CYCLES   (RELEASE_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .ackPending(reqAck),
    .strobes   (strobes)
  );

  sram_ctrl_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .READ_CYCLES   (READ_CYCLES),
    .LOW_CYCLES    (LOW_CYCLES),
    .RELEASE_CYCLES(RELEASE_CYCLES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqAck  (reqAck),
    .rdData  (rdData),
    .memCe1N (memCe1N),
    .memCe2  (memCe2),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqIn (memDqIn),
    .memDqOe (memDqOe)
  );

endmodule

// File: tb/async_sram_ctrl_bench.sv
module async_sram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int READ_CYC   = 6;
  localparam int WP_CYC     = 3;
  localparam int DS_CYC     = 3;
  localparam int REL_CYC    = 3;
  // memory limits in cycles, from the nanosecond figures at this clock
  localparam int AA_LIM  = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WP_LIM  = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int DW_LIM  = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int AW_LIM  = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int OHZ_LIM = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int LOW_EXP = (WP_CYC > DS_CYC) ? ((WP_CYC > READ_CYC - 1) ? WP_CYC : READ_CYC - 1)
                                             : ((DS_CYC > READ_CYC - 1) ? DS_CYC : READ_CYC - 1);
  localparam int RD_LAT  = READ_CYC;
  localparam int WR_LAT  = LOW_EXP + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqAck;
  logic [DATA_W-1:0] rdData;
  logic memCe1N, memCe2, memOeN, memWeN, memDqOe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memDqOut, memDqIn;

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_sram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_CYCLES(READ_CYC),
    .WE_PULSE_CYCLES(WP_CYC), .DATA_SETUP_CYCLES(DS_CYC), .RELEASE_CYCLES(REL_CYC)
  ) u_async_sram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rdData(rdData),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  // ---------------- behavioural memory model ----------------
  logic [DATA_W-1:0] modelMem [DEPTH];
  int rdCnt, tail, lowCnt, dataCnt, addrCnt;
  bit rdPrev, waPrev;
  logic [ADDR_W-1:0] lastAddr, wAddr;
  logic [DATA_W-1:0] lastDq, wData;
  int contentionCnt, wrTimingViol, addrViol, rdAddrViol, oeWeViol;

  wire modelSel = !memCe1N && memCe2;
  wire modelRd  = modelSel && !memOeN && memWeN;
  wire modelWa  = modelSel && !memWeN;
  assign memDqIn = (rdCnt + 1 >= AA_LIM) ? modelMem[memAddr] : ~modelMem[memAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) modelMem[i] <= '0;
      rdCnt <= 0; tail <= 0; lowCnt <= 0; dataCnt <= 0; addrCnt <= 0;
      rdPrev <= 0; waPrev <= 0; lastAddr <= '0; lastDq <= '0; wAddr <= '0; wData <= '0;
      contentionCnt <= 0; wrTimingViol <= 0; addrViol <= 0; rdAddrViol <= 0; oeWeViol <= 0;
    end else begin
      rdCnt <= modelRd ? rdCnt + 1 : 0;
      if (modelRd && rdPrev && memAddr != lastAddr) rdAddrViol <= rdAddrViol + 1;
      if (memDqOe && (modelRd || tail != 0)) contentionCnt <= contentionCnt + 1;
      tail <= modelRd ? OHZ_LIM : ((tail != 0) ? tail - 1 : 0);
      if (!memOeN && !memWeN) oeWeViol <= oeWeViol + 1;
      lowCnt  <= modelWa ? lowCnt + 1 : 0;
      dataCnt <= memDqOe ? ((dataCnt != 0 && memDqOut == lastDq) ? dataCnt + 1 : 1) : 0;
      addrCnt <= modelSel ? ((addrCnt != 0 && memAddr == lastAddr) ? addrCnt + 1 : 1) : 0;
      if (modelWa && waPrev && memAddr != lastAddr) addrViol <= addrViol + 1;
      if (modelWa) begin
        wAddr <= memAddr;
        wData <= memDqOut;
      end
      if (!modelWa && waPrev) begin
        if (lowCnt < WP_LIM || dataCnt < DW_LIM || addrCnt < AW_LIM)
          wrTimingViol <= wrTimingViol + 1;
        modelMem[wAddr] <= wData;
      end
      rdPrev <= modelRd; waPrev <= modelWa;
      lastAddr <= memAddr; lastDq <= memDqOut;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  int shadow [DEPTH];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runAccess(input bit isWrite, input int addr, input int data,
                           input bit scramble, input bit keepValid, output int got);
    int lat, guard;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = isWrite;
    reqAddr = ADDR_W'(addr); reqWdata = DATA_W'(data);
    @(posedge clk);
    lat = 0; guard = 0;
    forever begin
      @(negedge clk);
      if (scramble) begin reqAddr = ~reqAddr; reqWdata = ~reqWdata; reqWrite = ~reqWrite; end
      if (reqAck) break;
      guard++;
      if (guard > 100) begin check(0, "R2/R3 ack timeout", guard, 0); break; end
      @(posedge clk); lat++;
    end
    got = int'(rdData);
    if (isWrite) check(lat == WR_LAT, "R3 write ack latency", lat, WR_LAT);
    else         check(lat == RD_LAT, "R2 read ack latency", lat, RD_LAT);
    if (!keepValid) reqValid = 1'b0;
    @(negedge clk);
    check(memCe1N && !memCe2 && memOeN && memWeN && !memDqOe, "R1 idle pins after ack",
          {memCe1N, memCe2, memOeN, memWeN, memDqOe}, 5'b10110);
    check(!reqAck, "R4 ack single cycle", reqAck, 0);
    reqValid = 1'b0;
    repeat (REL_CYC - 1) @(negedge clk);
  endtask

  task automatic doWrite(input int addr, input int data);
    int dummy;
    runAccess(1'b1, addr, data, 1'b0, 1'b0, dummy);
    shadow[addr] = data & 8'hFF;
  endtask

  task automatic doRead(input int addr, input string tag);
    int got;
    runAccess(1'b0, addr, 0, 1'b0, 1'b0, got);
    check(got == shadow[addr], tag, got, shadow[addr]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int got;
    for (int i = 0; i < DEPTH; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(memCe1N && !memCe2 && memOeN && memWeN && !memDqOe && !reqAck,
          "R1 reset pins", {memCe1N, memCe2, memOeN, memWeN, memDqOe, reqAck}, 6'b101100);
    check(rdData == 0, "R1 reset rdData", rdData, 0);

    // exhaustive write then read sweep (R2, R3, R7)
    for (int a = 0; a < DEPTH; a++) doWrite(a, (a * 37 + 11) & 8'hFF);
    for (int a = 0; a < DEPTH; a++) doRead(a, "R7 sweep read");

    // descending read-after-write with a new pattern, read->write turnaround (R6)
    for (int a = DEPTH - 1; a >= 0; a--) begin
      doWrite(a, (a ^ 8'hC3) & 8'hFF);
      doRead(a, "R7 read after write");
    end

    // random mix
    for (int k = 0; k < 60; k++) begin
      int a;
      a = $urandom_range(0, DEPTH - 1);
      if ($urandom_range(0, 1) == 1) doWrite(a, $urandom_range(0, 255));
      else doRead(a, "R7 random read");
    end

    // R9: request fields changed during a write are ignored
    runAccess(1'b1, 9, 8'h5A, 1'b1, 1'b0, got);
    shadow[9] = 8'h5A;
    doRead(9, "R9 scrambled write target");
    doRead(9 ^ (DEPTH - 1), "R9 scrambled write other addr");

    // R7: rdData holds across a following write
    runAccess(1'b0, 17, 0, 1'b0, 1'b0, got);
    doWrite(18, 8'h81);
    check(int'(rdData) == shadow[17], "R7 rdData held", rdData, shadow[17]);

    // R4: request held through the ack cycle is not taken again
    runAccess(1'b1, 30, 8'h3E, 1'b0, 1'b1, got);
    shadow[30] = 8'h3E;
    @(negedge clk);
    check(memCe1N, "R4 no second acceptance", memCe1N, 1);
    doRead(30, "R4 data after held request");

    // model-side checks
    check(contentionCnt == 0, "R6 bus contention", contentionCnt, 0);
    check(wrTimingViol == 0, "R3 write timing", wrTimingViol, 0);
    check(addrViol == 0, "R5 address change in write", addrViol, 0);
    check(rdAddrViol == 0, "R2 address change in read", rdAddrViol, 0);
    check(oeWeViol == 0, "R8 oe and we both low", oeWeViol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule